// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Datapath

This block is the datapath of a 32-bit processor that runs one instruction per clock. It supports six instructions: unsigned add, unsigned subtract, OR with immediate, word load, word store and branch-if-equal. It holds the program counter and its next-address logic, an instruction store, a 32-entry register file with two read ports and one write port, an immediate extender, the ALU with a mux on its second operand, a data store, and the muxes that pick the destination register and the write-back value.

The datapath makes no decisions of its own. An external decoder reads the fetched instruction word and the ALU zero flag, and drives eight control points. These control points pick the destination field, the ALU operand, the extension mode, the write-back source, the two write enables, the ALU operation and the PC source. Both stores are plain internal word arrays that the testbench fills before reset is released. Each store is indexed by address bits [31:2].

The ALU result and the second register read value are also brought out as outputs. A decoder or a bench can then see each register transfer as it happens.

Top module: `sc_datapath`

## Requirements
- R1: Synchronous active-low reset sets the PC to 0 and clears all 32 registers. The first cycle after reset fetches word 0, and every register reads 0.
- R2: Register 0 always reads 0, and a write to it is dropped. Every other register returns the last value written to it, from the clock edge after the write.
- R3: When alu_op=00 (add), sel_rd_dst=1 and reg_we=1, the register named by bits [15:11] receives the sum of the registers named by bits [25:21] and [20:16], modulo 2^32.
- R4: With alu_op=01 (subtract) and the same other settings, that register receives the [25:21] operand minus the [20:16] operand, modulo 2^32.
- R5: When alu_op=10 (OR), sel_b_imm=1 and ext_signed=0, the register named by bits [20:16] receives the [25:21] operand ORed with bits [15:0] zero-extended.
- R6: When take_branch=0, the PC advances by 4 on every clock.
- R7: When take_branch=1, the next PC is PC+4 plus bits [15:0] sign-extended and shifted left by 2. Negative offsets move the PC backward.
- R8: With ext_signed=1 and sel_b_imm=1, the address is the [25:21] operand plus bits [15:0] sign-extended. With sel_wb_mem=1, the data word at address bits [31:2] is written to the register named by bits [20:16].
- R9: When mem_we=1, the [20:16] register value is written at the clock edge into the data word addressed by alu_result_o bits [31:2]. That value also appears on store_data_o. When reg_we=0, no register changes.
- R10: alu_zero_o is 1 exactly when alu_result_o is 0.
- R11: instr_o equals the instruction word at index pc_o bits [31:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_rd_dst | input | 1 | Destination register: 0 selects bits [20:16], 1 selects bits [15:11] |
| sel_b_imm | input | 1 | ALU second operand: 0 selects register read B, 1 selects the extended immediate |
| ext_signed | input | 1 | Immediate extension: 0 zero-extends, 1 sign-extends |
| sel_wb_mem | input | 1 | Write-back value: 0 selects the ALU result, 1 selects the data-store read |
| mem_we | input | 1 | Data-store write enable |
| reg_we | input | 1 | Register-file write enable |
| alu_op | input | 2 | ALU operation: 00 add, 01 subtract, 10 OR (11 also gives OR) |
| take_branch | input | 1 | Next PC is the branch target when 1 |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Fetched instruction word |
| alu_zero_o | output | 1 | ALU result equals zero |
| alu_result_o | output | 32 | ALU result, which is also the data-store address |
| store_data_o | output | 32 | Register read B value, which is the store data |

## Verification
The assertions check on every cycle the following properties:
- the PC steps by 4, or by the branch offset, and returns to 0 after reset;
- a subtraction added back to its second operand gives the first operand, and equal operands raise the zero flag;
- a written register, or a written data word, reads back the written value on the next cycle.

The bench's program can show the rest:
- the full set of decoded register transfers, and the fields each one selects;
- zero versus sign extension;
- writes to register 0 being dropped;
- loads of preloaded data;
- branches taken forward, taken backward and not taken.

The bench checks these against a behavioural model of the instruction set on every clock.

// File: rtl/sc_dp_pkg.sv
// Shared types for the single-cycle datapath.
// Assumes a 2-bit operation select driven by the external decoder.
package sc_dp_pkg;
    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;
endpackage

// File: rtl/sc_pc_unit.sv
// Program counter with next-address selection.
// Assumes word-aligned code; the branch offset is a signed word count.
module sc_pc_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_branch,
    input  logic [15:0]     offset16,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_disp;
    logic [XLEN-1:0] nxt_pc;

    // Sequential successor and branch displacement in bytes.
    always_comb begin
        seq_pc  = pc + XLEN'(4);
        br_disp = {{(XLEN-18){offset16[15]}}, offset16, 2'b00};
        nxt_pc  = take_branch ? seq_pc + br_disp : seq_pc;
    end

    // PC register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= nxt_pc;
    end

    assert_pc_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pc == '0);
    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_branch |=> pc == $past(pc) + XLEN'(4));
    assert_pc_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch |=> pc == $past(pc) + XLEN'(4)
                         + {{(XLEN-18){$past(offset16[15])}}, $past(offset16), 2'b00});
endmodule

// File: rtl/sc_regfile.sv
// Register file: NREG words, two combinational reads, one clocked write.
// Assumes entry 0 is hard zero; reset clears every entry.
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    // Write port; entry 0 is never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Read ports with entry 0 forced to zero.
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    end

    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (ra_a != $past(wa)) || (rd_a == $past(wd)));
    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (ra_a != '0) || (rd_a == '0));
endmodule

// File: rtl/sc_alu.sv
// ALU: add, subtract or OR, with a zero flag.
// Assumes unsigned wrap-around arithmetic; code 11 behaves as OR.
module sc_alu
    import sc_dp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    // Operation select.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a | b;
        endcase
        zero = (y == '0);
    end

    assert_sub_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == ALU_SUB |-> y + b == a);
    assert_equal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ALU_SUB && a == b) |-> zero);
endmodule

// File: rtl/sc_imem.sv
// Instruction store: WORDS words, combinational read by address bits above 1:0.
// Assumes contents are loaded by the environment before reset ends.
module sc_imem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] data
);
    logic [XLEN-1:0] mem [WORDS];
    logic            unused_addr_bits;

    // Power-up contents cleared; the environment overwrites them.
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    // Word read.
    assign data = mem[addr[IW+1:2]];
    assign unused_addr_bits = ^{addr[XLEN-1:IW+2], addr[1:0]};
endmodule

// File: rtl/sc_dmem.sv
// Data store: WORDS words, combinational read, clocked write.
// Assumes word accesses only; the upper address bits are ignored.
module sc_dmem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] mem [WORDS];
    logic [IW-1:0]   idx;
    logic            unused_addr_bits;

    assign idx = addr[IW+1:2];
    assign unused_addr_bits = ^{addr[XLEN-1:IW+2], addr[1:0]};

    // Power-up contents cleared; the environment overwrites them.
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Read port.
    assign rdata = mem[idx];

    assert_store_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (idx != $past(idx)) || (rdata == $past(wdata)));
endmodule

// File: rtl/sc_datapath.sv
// Single-cycle datapath top: fetch, register read, extend, ALU, data store,
// write-back and next PC in one clock. Control points come from an external
// decoder that watches instr_o and alu_zero_o.
module sc_datapath
    import sc_dp_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NREG        = 32,
    parameter int IMEM_WORDS  = 64,
    parameter int DMEM_WORDS  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_rd_dst,
    input  logic            sel_b_imm,
    input  logic            ext_signed,
    input  logic            sel_wb_mem,
    input  logic            mem_we,
    input  logic            reg_we,
    input  logic [1:0]      alu_op,
    input  logic            take_branch,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            alu_zero_o,
    output logic [XLEN-1:0] alu_result_o,
    output logic [XLEN-1:0] store_data_o
);
    localparam int RW = $clog2(NREG);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr;
    logic [RW-1:0]   f_src_a, f_src_b, f_dst_r;
    logic [15:0]     f_imm;
    logic [RW-1:0]   wr_sel;
    logic [XLEN-1:0] bus_a, bus_b, imm_ext, alu_b, alu_y, mem_rd, wb_val;
    logic            zero;
    logic            unused_fields;

    // Field extraction from the fetched word.
    always_comb begin
        f_src_a = instr[21 +: RW];
        f_src_b = instr[16 +: RW];
        f_dst_r = instr[11 +: RW];
        f_imm   = instr[15:0];
    end
    assign unused_fields = ^instr[31:26];

    // Destination, extension, operand and write-back muxes.
    always_comb begin
        wr_sel  = sel_rd_dst ? f_dst_r : f_src_b;
        imm_ext = ext_signed ? {{(XLEN-16){f_imm[15]}}, f_imm} : {{(XLEN-16){1'b0}}, f_imm};
        alu_b   = sel_b_imm ? imm_ext : bus_b;
        wb_val  = sel_wb_mem ? mem_rd : alu_y;
    end

    sc_pc_unit #(.XLEN(XLEN)) u_pc (
        .clk(clk), .rst_n(rst_n), .take_branch(take_branch),
        .offset16(f_imm), .pc(pc)
    );

    sc_imem #(.XLEN(XLEN), .WORDS(IMEM_WORDS)) u_imem (
        .addr(pc), .data(instr)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(f_src_a), .ra_b(f_src_b), .rd_a(bus_a), .rd_b(bus_b),
        .we(reg_we), .wa(wr_sel), .wd(wb_val)
    );

    sc_alu #(.XLEN(XLEN)) u_alu (
        .clk(clk), .rst_n(rst_n), .op(alu_op_e'(alu_op)),
        .a(bus_a), .b(alu_b), .y(alu_y), .zero(zero)
    );

    sc_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(alu_y),
        .wdata(bus_b), .rdata(mem_rd)
    );

    // Observation outputs.
    always_comb begin
        pc_o         = pc;
        instr_o      = instr;
        alu_zero_o   = zero;
        alu_result_o = alu_y;
        store_data_o = bus_b;
    end

    assert_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_branch |=> instr_o == u_imem.mem[$past(pc[$clog2(IMEM_WORDS)+1:2]) + 1'b1]);
endmodule

// File: tb/sc_datapath_tb.sv
// Bench: acts as the decoder and keeps a behavioural instruction-set model.
module sc_datapath_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_rd_dst = 0, sel_b_imm = 0, ext_signed = 0, sel_wb_mem = 0;
    logic        mem_we = 0, reg_we = 0, take_branch = 0;
    logic [1:0]  alu_op = 2'b00;
    logic [31:0] pc_o, instr_o, alu_result_o, store_data_o;
    logic        alu_zero_o;

    always #2.5 clk = ~clk;

    sc_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .sel_rd_dst(sel_rd_dst), .sel_b_imm(sel_b_imm),
        .ext_signed(ext_signed), .sel_wb_mem(sel_wb_mem), .mem_we(mem_we),
        .reg_we(reg_we), .alu_op(alu_op), .take_branch(take_branch),
        .pc_o(pc_o), .instr_o(instr_o), .alu_zero_o(alu_zero_o),
        .alu_result_o(alu_result_o), .store_data_o(store_data_o)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] prog [int];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [int];
    logic [31:0] m_pc;
    string       last_pc_tag;

    function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] ifmt(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h (pc=%h)", tag, what, act, exp, m_pc);
        end
    endtask

    function automatic logic [31:0] fetch(input logic [31:0] a);
        return prog.exists(a[31:2]) ? prog[a[31:2]] : 32'd0;
    endfunction
    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return m_mem.exists(a[7:2]) ? m_mem[a[7:2]] : 32'd0;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 5000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins, a, b, sx, zx, y, res;
        int op, fn, rs, rt, rd;
        bit wr; int wdst; bit br;
        // Program: opcodes R-type 0 (funct 21h add, 23h sub), 0Dh ori, 23h lw, 2Bh sw, 04h beq.
        prog[0]  = ifmt(6'h0D, 0, 1, 16'h8001);  // ori r1 zero-extended (R5)
        prog[1]  = ifmt(6'h0D, 0, 2, 16'h0010);
        prog[2]  = rfmt(1, 2, 3, 6'h21);          // addu (R3)
        prog[3]  = rfmt(2, 1, 4, 6'h23);          // subu negative (R4)
        prog[4]  = ifmt(6'h0D, 1, 0, 16'h00FF);  // write to r0 dropped (R2)
        prog[5]  = rfmt(0, 0, 5, 6'h21);          // r0 reads zero (R2)
        prog[6]  = ifmt(6'h2B, 2, 3, 16'hFFFC);  // sw negative offset (R9)
        prog[7]  = ifmt(6'h23, 2, 6, 16'hFFFC);  // lw back (R8)
        prog[8]  = ifmt(6'h23, 0, 7, 16'h0004);  // lw preloaded word
        prog[9]  = ifmt(6'h04, 6, 3, 16'h0001);  // beq taken forward (R7)
        prog[10] = ifmt(6'h0D, 0, 8, 16'h1234);  // skipped
        prog[11] = ifmt(6'h04, 1, 2, 16'h0005);  // beq not taken
        prog[12] = ifmt(6'h0D, 0, 12, 16'h0001);
        prog[13] = ifmt(6'h0D, 0, 10, 16'h0003);
        prog[14] = rfmt(11, 10, 11, 6'h21);
        prog[15] = rfmt(10, 12, 10, 6'h23);
        prog[16] = ifmt(6'h04, 10, 0, 16'h0001);
        prog[17] = ifmt(6'h04, 0, 0, 16'hFFFC);  // backward branch
        prog[18] = rfmt(11, 0, 13, 6'h21);
        prog[19] = rfmt(7, 1, 14, 6'h21);
        prog[20] = rfmt(8, 0, 15, 6'h21);
        prog[21] = ifmt(6'h04, 0, 0, 16'hFFFF);  // self loop
        #1;
        foreach (prog[i]) u_dut.u_imem.mem[i] = prog[i];
        u_dut.u_dmem.mem[1] = 32'hDEADBEEF;
        m_mem[1] = 32'hDEADBEEF;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        m_pc = 32'd0;
        last_pc_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "pc after reset", pc_o, 32'd0);
        check("R1", "register read after reset", store_data_o, 32'd0);

        for (int cyc = 0; cyc < 60; cyc++) begin
            ins = fetch(m_pc);
            op = ins[31:26]; fn = ins[5:0];
            rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
            a = m_reg[rs]; b = m_reg[rt];
            sx = {{16{ins[15]}}, ins[15:0]};
            zx = {16'd0, ins[15:0]};
            {sel_rd_dst, sel_b_imm, ext_signed, sel_wb_mem, mem_we, reg_we, take_branch} = '0;
            alu_op = 2'b00;
            wr = 0; wdst = 0; br = 0; y = 32'd0; res = 32'd0;
            if (op == 0 && (fn == 6'h21 || fn == 6'h23)) begin
                sel_rd_dst = 1; reg_we = 1;
                alu_op = (fn == 6'h23) ? 2'b01 : 2'b00;
                y = (fn == 6'h23) ? a - b : a + b;
                res = y; wr = 1; wdst = rd;
            end else if (op == 6'h0D) begin
                sel_b_imm = 1; reg_we = 1; alu_op = 2'b10;
                y = a | zx; res = y; wr = 1; wdst = rt;
            end else if (op == 6'h23) begin
                sel_b_imm = 1; ext_signed = 1; sel_wb_mem = 1; reg_we = 1;
                y = a + sx; res = rd_mem(y); wr = 1; wdst = rt;
            end else if (op == 6'h2B) begin
                sel_b_imm = 1; ext_signed = 1; mem_we = 1;
                y = a + sx;
            end else if (op == 6'h04) begin
                alu_op = 2'b01; y = a - b;
                br = (a == b); take_branch = br;
            end
            #1;
            check(last_pc_tag, "pc", pc_o, m_pc);
            check("R11", "instr", instr_o, ins);
            if (op == 0 && (rs == 0 || rt == 0))
                check("R2", "alu result with r0 operand", alu_result_o, y);
            else if (op == 0 && fn == 6'h23) check("R4", "subtract result", alu_result_o, y);
            else if (op == 0) check("R3", "add result", alu_result_o, y);
            else if (op == 6'h0D) check("R5", "ori zero-extended", alu_result_o, y);
            else if (op == 6'h23 || op == 6'h2B) check("R8", "address", alu_result_o, y);
            else check("R7", "compare result", alu_result_o, y);
            check("R10", "zero flag", {31'd0, alu_zero_o}, {31'd0, y == 32'd0});
            check("R9", "store data", store_data_o, b);
            // Advance the model to the state after the coming edge.
            if (wr && wdst != 0) m_reg[wdst] = res;
            if (op == 6'h2B) m_mem[y[7:2]] = b;
            last_pc_tag = br ? "R7" : "R6";
            m_pc = m_pc + 32'd4 + (br ? {sx[29:0], 2'b00} : 32'd0);
            @(negedge clk);
        end
        // Final register state, read out through add-with-r0 instructions above.
        check("R2", "r8 never written (skipped)", m_reg[8], 32'd0);
        check("R3", "loop sum model", m_reg[13], 32'd6);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule